// File: doc/BRIEF.md
# Multi-Mode Host Bus Front End

This block sits between an 8-bit host processor bus and a chip's internal register file. It works out which bus style the board uses from the level or activity of the address-latch-enable pin: a steady high selects the strobe-plus-read/write style, a steady low selects the separate read and write strobe style with its own address pins, and any ALE transition switches to multiplexed address/data operation. The multiplexed choice stays until reset. All bus pins pass through synchronizers into the internal clock domain. Each bus access then becomes a single-cycle request on an internal register port.

An address-mode pin can shrink the visible address space to two locations. Address bit 0 low selects a pointer register held inside this block. Address bit 0 high selects a data window that reaches whichever internal register the pointer names. This indirect scheme works the same way over all three bus styles. Read requests are issued when the strobe opens, so the returned byte is ready to drive while the strobe stays active. Write requests are issued when the strobe closes, carrying the last data byte seen on the bus.

Top module: `mpbus_front`

## Requirements
- R1: After reset, no request is issued, the data bus is not driven, and a read of the pointer location (address-mode pin high, A0 = 0) returns 0x00.
- R2: With ALE held low, a write (chip select low, write strobe low) produces exactly one write request after the strobe rises, carrying the address pins and the data bus value.
- R3: With ALE held low, a read (chip select low, read strobe low) produces one read request carrying the address pins, and the data bus then drives the byte the register file returns.
- R4: With ALE held high, the read strobe pin acts as an active-low data strobe and the write strobe pin as read/write (high = read, low = write). A write request is issued when the data strobe rises.
- R5: After any ALE edge, the address is the value on the data bus while ALE was high, and the address pins are ignored.
- R6: Multiplexed mode persists when ALE stops toggling and is left only through reset. After reset with ALE low, the address pins are used again.
- R7: With chip select high, strobes produce no request and the bus is not driven.
- R8: With the address-mode pin high, an A0 = 0 write loads the pointer and issues no internal request. An A0 = 0 read drives the pointer value.
- R9: With the address-mode pin high, an A0 = 1 access issues a request at the pointer address. The pointer does not change afterwards.
- R10: An access produces exactly one request pulse, however long the strobe is held.
- R11: The data bus drive enable is high only while chip select is low and a read strobe is active (in the strobe/read-write style: data strobe low with read/write high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, or data strobe in the strobe/read-write style |
| wr_n | input | 1 | Write strobe, or read/write (high = read) in the strobe/read-write style |
| ale | input | 1 | Address latch enable; its level or its edges select the bus style |
| amode | input | 1 | High selects two-location indirect access |
| addr | input | 8 | Address pins (non-multiplexed styles) |
| dbus_in | input | 8 | Data bus input (also the address in multiplexed mode) |
| dbus_out | output | 8 | Data bus output value |
| dbus_oe | output | 1 | Data bus drive enable |
| req_valid | output | 1 | Single-cycle internal request |
| req_write | output | 1 | Request is a write |
| req_addr | output | 8 | Internal register address |
| req_wdata | output | 8 | Internal write data |
| reg_rdata | input | 8 | Read data from the register file, sampled in the cycle req_valid is high |

## Verification
The hardest state to reach is the sticky multiplexed mode and the return from it. A single ALE pulse does not show whether the mode truly locks. So the bench first pulses ALE once, then performs an access with ALE quiet and the address pins set to a different value. The request must still carry the last latched address. A reset with ALE low must then bring back use of the address pins. The steady-high style can only be entered cleanly from reset, because raising ALE later would itself count as an edge. For that reason the bench runs separate reset phases for the ALE-low, ALE-high and multiplexed cases.

// File: rtl/mpbus_pkg.sv
package mpbus_pkg;
    localparam int DW = 8;
    localparam int AW = 8;

    typedef enum logic [1:0] {
        BUS_SPLIT = 2'd0,
        BUS_DSRW  = 2'd1,
        BUS_MUXED = 2'd2
    } bus_mode_e;

    typedef struct packed {
        logic sel;
        logic wr;
    } strobe_t;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } req_t;

    function automatic strobe_t decode_strobe(bus_mode_e m, logic cs_n, logic rd_n, logic wr_n);
        strobe_t s;
        if (m == BUS_DSRW) begin
            s.sel = !cs_n && !rd_n;
            s.wr  = !wr_n;
        end else begin
            s.sel = !cs_n && (!rd_n || !wr_n);
            s.wr  = !wr_n;
        end
        return s;
    endfunction
endpackage

// File: rtl/mpbus_sync.sv
module mpbus_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) st[0] <= d;

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) st[i] <= st[i-1];
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/mpbus_mode_det.sv
module mpbus_mode_det
    import mpbus_pkg::*;
#(
    parameter int PRIME = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ale_s,
    output bus_mode_e mode,
    output logic      primed
);
    localparam int CW = $clog2(PRIME + 1);

    logic [CW-1:0] cnt;
    logic          ale_prev;

    assign primed = (cnt == CW'(PRIME));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            ale_prev <= 1'b0;
            mode     <= BUS_SPLIT;
        end else begin
            ale_prev <= ale_s;
            if (!primed) begin
                cnt <= cnt + 1'b1;
            end else if (mode != BUS_MUXED) begin
                if (ale_s != ale_prev) mode <= BUS_MUXED;
                else                   mode <= ale_s ? BUS_DSRW : BUS_SPLIT;
            end
        end
    end
endmodule

// File: rtl/mpbus_strobe.sv
module mpbus_strobe
    import mpbus_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  bus_mode_e     mode,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] data,
    output logic          start_any,
    output logic          start_rd,
    output logic          end_wr,
    output logic [DW-1:0] wdata
);
    strobe_t now;
    logic    sel_now;
    logic    act_q;
    logic    wr_q;

    always_comb begin
        now     = decode_strobe(mode, cs_n, rd_n, wr_n);
        sel_now = en && now.sel;
    end

    assign start_any = sel_now && !act_q;
    assign start_rd  = start_any && !now.wr;
    assign end_wr    = !sel_now && act_q && wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            wr_q  <= 1'b0;
            wdata <= '0;
        end else begin
            act_q <= sel_now;
            if (start_any)          wr_q  <= now.wr;
            if (sel_now && now.wr)  wdata <= data;
        end
    end
endmodule

// File: rtl/mpbus_front.sv
module mpbus_front
    import mpbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          ale,
    input  logic          amode,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dbus_in,
    output logic [DW-1:0] dbus_out,
    output logic          dbus_oe,
    output logic          req_valid,
    output logic          req_write,
    output logic [AW-1:0] req_addr,
    output logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] reg_rdata
);
    localparam int PRIME = SYNC_STAGES + 1;
    localparam int SW    = 5 + AW + DW;

    logic [SW-1:0] pins_s;
    logic          cs_n_s, rd_n_s, wr_n_s, ale_s, amode_s;
    logic [AW-1:0] addr_s;
    logic [DW-1:0] dbus_s;

    mpbus_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   ({cs_n, rd_n, wr_n, ale, amode, addr, dbus_in}),
        .q   (pins_s)
    );
    assign {cs_n_s, rd_n_s, wr_n_s, ale_s, amode_s, addr_s, dbus_s} = pins_s;

    bus_mode_e mode;
    logic      primed;

    mpbus_mode_det #(.PRIME(PRIME)) u_mode (
        .clk    (clk),
        .rst    (rst),
        .ale_s  (ale_s),
        .mode   (mode),
        .primed (primed)
    );

    logic          start_any, start_rd, end_wr;
    logic [DW-1:0] wdata;

    mpbus_strobe u_strobe (
        .clk       (clk),
        .rst       (rst),
        .en        (primed),
        .mode      (mode),
        .cs_n      (cs_n_s),
        .rd_n      (rd_n_s),
        .wr_n      (wr_n_s),
        .data      (dbus_s),
        .start_any (start_any),
        .start_rd  (start_rd),
        .end_wr    (end_wr),
        .wdata     (wdata)
    );

    logic [AW-1:0] mux_addr;
    logic [AW-1:0] cur_addr;
    logic          cur_ind;
    logic [AW-1:0] ptr;
    logic [DW-1:0] rd_hold;
    logic [AW-1:0] eff_addr;
    strobe_t       pin_strobe;

    assign eff_addr = (mode == BUS_MUXED) ? mux_addr : addr_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            mux_addr  <= '0;
            cur_addr  <= '0;
            cur_ind   <= 1'b0;
            ptr       <= '0;
            rd_hold   <= '0;
            req_valid <= 1'b0;
            req_write <= 1'b0;
            req_addr  <= '0;
            req_wdata <= '0;
        end else begin
            req_valid <= 1'b0;
            if (ale_s) mux_addr <= dbus_s;
            if (req_valid && !req_write) rd_hold <= reg_rdata;
            if (start_any) begin
                cur_addr <= eff_addr;
                cur_ind  <= amode_s;
            end
            if (start_rd) begin
                if (amode_s && !eff_addr[0]) begin
                    rd_hold <= ptr;
                end else begin
                    req_valid <= 1'b1;
                    req_write <= 1'b0;
                    req_addr  <= amode_s ? ptr : eff_addr;
                end
            end
            if (end_wr) begin
                if (cur_ind && !cur_addr[0]) begin
                    ptr <= wdata;
                end else begin
                    req_valid <= 1'b1;
                    req_write <= 1'b1;
                    req_addr  <= cur_ind ? ptr : cur_addr;
                    req_wdata <= wdata;
                end
            end
        end
    end

    always_comb begin
        pin_strobe = decode_strobe(mode, cs_n, rd_n, wr_n);
        dbus_oe    = pin_strobe.sel && !pin_strobe.wr;
    end
    assign dbus_out = rd_hold;
endmodule

// File: rtl/mpbus_front_chk.sv
module mpbus_front_chk
    import mpbus_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      cs_n,
    input logic      rd_n,
    input logic      req_valid,
    input logic      dbus_oe,
    input bus_mode_e mode
);
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid); // R10

    AST_MUX_STICKY: assert property (@(posedge clk) disable iff (rst)
        (mode == BUS_MUXED) |=> (mode == BUS_MUXED)); // R6

    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        dbus_oe |-> !cs_n); // R7

    AST_OE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        dbus_oe |-> !rd_n); // R11
endmodule

bind mpbus_front mpbus_front_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .req_valid (req_valid),
    .dbus_oe   (dbus_oe),
    .mode      (mode)
);

// File: tb/test_mpbus_front.sv
`timescale 1ns/1ps
module test_mpbus_front;
    import mpbus_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ale = 1'b0, amode = 1'b0;
    logic [7:0] addr = 8'h00, dbus_in = 8'h00;
    logic [7:0] dbus_out, req_addr, req_wdata, reg_rdata;
    logic       dbus_oe, req_valid, req_write;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    req_t exp_q[$];

    always #2 clk = ~clk;

    assign reg_rdata = req_addr ^ 8'h5A;

    mpbus_front i_mpbus_front (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .ale(ale), .amode(amode), .addr(addr), .dbus_in(dbus_in),
        .dbus_out(dbus_out), .dbus_oe(dbus_oe), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pop and compare every request the design produces
    always @(negedge clk) begin
        if (!rst && req_valid) begin
            req_t e;
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R7/R8/R10 unexpected request actual=%0h expected=none", req_addr);
            end else begin
                e = exp_q.pop_front();
                if (req_write != e.wr || req_addr != e.addr || (e.wr && req_wdata != e.data)) begin
                    fails++;
                    $display("FAIL R2/R3/R4/R5/R9 request actual=%0h_%0h_%0h expected=%0h_%0h_%0h",
                             req_write, req_addr, req_wdata, e.wr, e.addr, e.data);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input bit ale_lvl);
        rst = 1'b1; ale = ale_lvl; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        cyc(6);
        rst = 1'b0;
        cyc(10);
    endtask

    task automatic expect_req(input bit wr, input [7:0] a, input [7:0] d);
        req_t e;
        e.wr = wr; e.addr = a; e.data = d;
        exp_q.push_back(e);
    endtask

    // dsrw: strobe/read-write style; hold: strobe length in cycles
    task automatic access(input bit dsrw, input bit wr, input [7:0] a, input [7:0] d,
                          input bit sel, input int hold,
                          output logic [7:0] seen, output logic oe_seen);
        addr = a; dbus_in = d;
        if (dsrw) wr_n = wr ? 1'b0 : 1'b1;
        cyc(2);
        cs_n = !sel;
        if (dsrw) rd_n = 1'b0;
        else if (wr) wr_n = 1'b0;
        else rd_n = 1'b0;
        cyc(hold);
        seen = dbus_out; oe_seen = dbus_oe;
        rd_n = 1'b1;
        if (!dsrw) wr_n = 1'b1;
        cyc(1);
        cs_n = 1'b1; wr_n = 1'b1;
        cyc(8);
    endtask

    task automatic ale_latch(input [7:0] a, input [7:0] pins);
        addr = pins; dbus_in = a; ale = 1'b1;
        cyc(4);
        ale = 1'b0;
        cyc(4);
    endtask

    initial begin
        logic [7:0] v;
        logic       oe;

        // R1: reset state
        do_reset(1'b0);
        check(req_valid == 1'b0, "R1 req idle", req_valid, 0);
        check(dbus_oe == 1'b0, "R1 bus idle", dbus_oe, 0);
        amode = 1'b1;
        access(1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 10, v, oe);
        check(v == 8'h00, "R1 pointer reset", v, 8'h00);
        amode = 1'b0;

        // R2 and R10: split-style write with a long strobe
        expect_req(1'b1, 8'h12, 8'h34);
        access(1'b0, 1'b1, 8'h12, 8'h34, 1'b1, 30, v, oe);
        check(oe == 1'b0, "R11 no drive on write", oe, 0);

        // R3 and R11: split-style read
        expect_req(1'b0, 8'h40, 8'h00);
        access(1'b0, 1'b0, 8'h40, 8'h00, 1'b1, 10, v, oe);
        check(v == 8'h1A, "R3 read data", v, 8'h1A);
        check(oe == 1'b1, "R11 drive during read", oe, 1);
        check(dbus_oe == 1'b0, "R11 released after read", dbus_oe, 0);

        // R7: chip select high
        access(1'b0, 1'b0, 8'h41, 8'h00, 1'b0, 10, v, oe);
        check(oe == 1'b0, "R7 no drive unselected", oe, 0);
        access(1'b0, 1'b1, 8'h41, 8'h99, 1'b0, 10, v, oe);
        check(exp_q.size() == 0, "R7 no request unselected", exp_q.size(), 0);

        // R8, R9: indirect access
        amode = 1'b1;
        access(1'b0, 1'b1, 8'h00, 8'h77, 1'b1, 10, v, oe);
        access(1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 10, v, oe);
        check(v == 8'h77, "R8 pointer readback", v, 8'h77);
        expect_req(1'b1, 8'h77, 8'h99);
        access(1'b0, 1'b1, 8'h01, 8'h99, 1'b1, 10, v, oe);
        expect_req(1'b0, 8'h77, 8'h00);
        access(1'b0, 1'b0, 8'h01, 8'h00, 1'b1, 10, v, oe);
        check(v == 8'h2D, "R9 window read data", v, 8'h2D);
        access(1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 10, v, oe);
        check(v == 8'h77, "R9 pointer unchanged", v, 8'h77);
        amode = 1'b0;

        // R4: strobe/read-write style
        do_reset(1'b1);
        expect_req(1'b1, 8'h21, 8'h5C);
        access(1'b1, 1'b1, 8'h21, 8'h5C, 1'b1, 10, v, oe);
        check(oe == 1'b0, "R4 no drive when rw low", oe, 0);
        expect_req(1'b0, 8'h21, 8'h00);
        access(1'b1, 1'b0, 8'h21, 8'h00, 1'b1, 10, v, oe);
        check(v == 8'h7B, "R4 read data", v, 8'h7B);
        check(oe == 1'b1, "R11 drive in dsrw read", oe, 1);

        // R5: first ALE edge switches to multiplexed
        ale_latch(8'h63, 8'hFF);
        expect_req(1'b1, 8'h63, 8'h0F);
        access(1'b0, 1'b1, 8'hFF, 8'h0F, 1'b1, 10, v, oe);
        ale_latch(8'h81, 8'hFF);
        expect_req(1'b0, 8'h81, 8'h00);
        access(1'b0, 1'b0, 8'hFF, 8'h00, 1'b1, 10, v, oe);
        check(v == 8'hDB, "R5 muxed read data", v, 8'hDB);

        // R6: sticky with ALE quiet, then reset restores pin addressing
        cyc(40);
        expect_req(1'b1, 8'h81, 8'h3C);
        access(1'b0, 1'b1, 8'h05, 8'h3C, 1'b1, 10, v, oe);
        do_reset(1'b0);
        expect_req(1'b1, 8'h05, 8'hC3);
        access(1'b0, 1'b1, 8'h05, 8'hC3, 1'b1, 10, v, oe);

        cyc(5);
        check(exp_q.size() == 0, "R2-all expected requests seen", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule